// File: doc/BRIEF.md
# Interleaved I/Q Splitter with 2x Interpolation

This block sits in front of a pair of DAC cores. It accepts a single stream of 10-bit offset-binary words in which in-phase (I) and quadrature (Q) samples take turns on the same bus. A select bit beside each word says which channel the word belongs to. A small pairing machine holds each I word until the Q word that follows it arrives. Only then does it commit the two as one pair into a one-deep pair buffer. A Q word that has no I word before it is discarded and reported.

Each committed pair feeds two identical interpolators, one per channel. Each interpolator doubles the sample rate with a 7-tap half-band filter on a zero-stuffed sequence, using the coefficients (-1, 0, 9, 16, 9, 0, -1)/16. Polyphase evaluation means each incoming sample yields two output beats. The first beat is the filtered midpoint. The second beat is the previous sample passed through unchanged. The two channels leave together in one output beat, so both DAC codes always change on the same clock edge.

The input stream uses valid/ready. A word is transferred only in a cycle where `in_valid` and `in_ready` are both high. The output stream also uses valid/ready. While `out_valid` is high and `out_ready` is low, the output beat is held unchanged. That stall reaches back to the pair buffer and then to `in_ready`. With `out_ready` held high, the block takes one word on every clock, so each channel's output rate is twice its input rate.

Top module: `iq_interp2x`

## Requirements
- R1: A word accepted with `in_sel`=1 is held as the pending I sample. The next accepted word with `in_sel`=0 forms a pair with it. If a second I word is accepted before any Q word, it replaces the pending I.
- R2: A word accepted with `in_sel`=0 while no I is pending is discarded. In that case `pair_err` is high for exactly the one cycle that follows the acceptance, and is low at every other time.
- R3: For each committed sample x[n] that produces output, the first beat for that sample is round((-x[n] + 9·x[n-1] + 9·x[n-2] - x[n-3]) / 16). The arithmetic works on the signed values (code - 512), and rounding adds 8 and then floors the division by 16.
- R4: A filtered result above +511 or below -512 is clamped to that limit. A clamped high result appears as code 1023 and a clamped low result as code 0.
- R5: Each committed pair that produces output gives exactly two beats, in this order: the filtered beat, then the beat carrying x[n-1] unchanged. Each beat carries both channels.
- R6: After reset or sleep, the first three committed pairs only fill the filter history and produce no output beat. The fourth pair produces the first beat.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_i` and `out_q` keep their values on the next cycle. No beat is lost or duplicated.
- R8: `in_ready` is low whenever `sleep` is high. No word is transferred in a cycle where `in_ready` is low.
- R9: One cycle after `sleep` is seen high, `out_i` and `out_q` are 512 and `out_valid` is 0. Sleep also clears the filter history, the pair buffer and any pending I word.
- R10: Synchronous reset leaves `out_i`=`out_q`=512, `out_valid`=0, `pair_err`=0 and `in_ready`=1 once reset is released.
- R11: With `out_ready` held high and `sleep` low, `in_ready` stays high on every cycle, so strict I/Q alternation runs at one word per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Forces mid-scale outputs and clears all history while high |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block accepts the input word this cycle |
| in_sel | input | 1 | 1: word is I, 0: word is Q |
| in_data | input | 10 | Offset-binary sample word |
| out_valid | output | 1 | Output beat is present |
| out_ready | input | 1 | Sink takes the output beat this cycle |
| out_i | output | 10 | I channel DAC code, offset binary |
| out_q | output | 10 | Q channel DAC code, offset binary |
| pair_err | output | 1 | One-cycle pulse for a discarded orphan Q word |

## Verification
The hardest situations to reach from the ports are the filter clamping limits and a sleep request that lands while a beat is held under back-pressure. Clamping needs four consecutive pairs with extreme codes in a particular arrangement. Directed pair sequences build those exact windows: 0, 1023, 1023, 0 on I and the mirror image on Q. The sleep-under-stall case is driven directly, and a long random phase adds randomly drawn valid, select, ready and occasional sleep. In that phase the same corners recur mixed with orphan Q words and repeated I words. A bench model of the pairing rules and the filter predicts every beat and every error pulse.

// File: rtl/iqi_pkg.sv
package iqi_pkg;
  typedef enum logic {
    PS_WAIT_I = 1'b0,
    PS_HAVE_I = 1'b1
  } pair_state_e;
endpackage

// File: rtl/iqi_pair_fsm.sv
module iqi_pair_fsm
  import iqi_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sel,
  input  logic [DW-1:0] in_data,
  input  logic          pair_take,
  output logic          pair_vld,
  output logic [DW-1:0] pair_i,
  output logic [DW-1:0] pair_q,
  output logic          pair_err
);
  pair_state_e   state;
  logic [DW-1:0] hold_i;
  logic          acc;

  // The buffer frees up in the same cycle the interpolator drains it.
  assign in_ready = !rst && !sleep && (!pair_vld || pair_take);
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      state    <= PS_WAIT_I;
      hold_i   <= '0;
      pair_vld <= 1'b0;
      pair_i   <= '0;
      pair_q   <= '0;
      pair_err <= 1'b0;
    end else begin
      pair_err <= 1'b0;
      if (pair_take) pair_vld <= 1'b0;
      if (acc) begin
        if (in_sel) begin
          hold_i <= in_data;
          state  <= PS_HAVE_I;
        end else if (state == PS_HAVE_I) begin
          pair_i   <= hold_i;
          pair_q   <= in_data;
          pair_vld <= 1'b1;
          state    <= PS_WAIT_I;
        end else begin
          pair_err <= 1'b1;
        end
      end
    end
  end

  // R8: a full pair buffer that is not drained keeps its contents
  a_r8_buf_kept: assert property (@(posedge clk) disable iff (rst)
    (pair_vld && !pair_take && !sleep) |=> (pair_vld && $stable(pair_i) && $stable(pair_q)));

  // R2: an error pulse only follows a word that left the machine waiting for I
  a_r2_err_in_wait: assert property (@(posedge clk) disable iff (rst)
    pair_err |-> (state == PS_WAIT_I));
endmodule

// File: rtl/iqi_hb_chan.sv
module iqi_hb_chan #(
  parameter int DW    = 10,
  parameter int K_IN  = 9,
  parameter int K_OUT = 1,
  parameter int SH    = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          shift,
  input  logic [DW-1:0] x_in,
  output logic [DW-1:0] y_a,
  output logic [DW-1:0] y_b
);
  localparam int HIST = 3;
  localparam int AW   = DW + $clog2(2 * (K_IN + K_OUT)) + 2;
  localparam logic signed [AW-1:0] KI  = AW'(K_IN);
  localparam logic signed [AW-1:0] KO  = AW'(K_OUT);
  localparam logic signed [AW-1:0] RND = AW'(1) <<< (SH - 1);
  localparam logic signed [AW-1:0] HI  = AW'((2 ** (DW - 1)) - 1);
  localparam logic signed [AW-1:0] LO  = -HI - AW'(1);

  logic signed [DW-1:0] x_s;
  logic signed [DW-1:0] hist [HIST];
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] rnd;
  logic signed [DW-1:0] sat;

  // offset binary to two's complement: invert the top bit
  assign x_s = {~x_in[DW-1], x_in[DW-2:0]};

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int k = 0; k < HIST; k++) hist[k] <= '0;
    end else if (shift) begin
      hist[0] <= x_s;
      for (int k = 1; k < HIST; k++) hist[k] <= hist[k-1];
    end
  end

  always_comb begin
    acc = KI * (AW'(hist[0]) + AW'(hist[1]))
        - KO * (AW'(x_s) + AW'(hist[2])) + RND;
    rnd = acc >>> SH;
    if (rnd > HI)      sat = HI[DW-1:0];
    else if (rnd < LO) sat = LO[DW-1:0];
    else               sat = rnd[DW-1:0];
  end

  assign y_a = {~sat[DW-1], sat[DW-2:0]};
  assign y_b = {~hist[1][DW-1], hist[1][DW-2:0]};
endmodule

// File: rtl/iqi_sched.sv
module iqi_sched #(
  parameter int PRIME = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  input  logic pair_vld,
  input  logic out_ready,
  output logic take,
  output logic emit_a,
  output logic emit_b,
  output logic out_valid
);
  localparam int FW = $clog2(PRIME + 1);

  logic          pend_b;
  logic [FW-1:0] fill;
  logic          primed;
  logic          load_ok;

  assign primed  = (fill == FW'(PRIME));
  assign load_ok = !out_valid || out_ready;
  assign emit_b  = !rst && !sleep && load_ok && pend_b;
  assign take    = !rst && !sleep && load_ok && !pend_b && pair_vld;
  assign emit_a  = take && primed;

  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      out_valid <= 1'b0;
      pend_b    <= 1'b0;
      fill      <= '0;
    end else if (load_ok) begin
      out_valid <= emit_a || emit_b;
      pend_b    <= emit_a;
      if (take && !primed) fill <= fill + FW'(1);
    end
  end

  // R5: the pass-through beat is owed only while the filtered beat is on the bus
  a_r5_b_after_a: assert property (@(posedge clk) disable iff (rst)
    pend_b |-> out_valid);

  // R6: history fills before anything is emitted
  a_r6_no_early_beat: assert property (@(posedge clk) disable iff (rst)
    (!primed && !pend_b) |=> !(out_valid && !$past(out_valid)) || $past(primed));
endmodule

// File: rtl/iq_interp2x.sv
module iq_interp2x #(
  parameter int DW    = 10,
  parameter int K_IN  = 9,
  parameter int K_OUT = 1,
  parameter int SH    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sel,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic          pair_err
);
  localparam int NCH   = 2;
  localparam int PRIME = 3;
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic          pair_vld, take, emit_a, emit_b;
  logic [DW-1:0] pair_i, pair_q;
  logic [DW-1:0] ch_x [NCH];
  logic [DW-1:0] ch_a [NCH];
  logic [DW-1:0] ch_b [NCH];

  iqi_pair_fsm #(.DW(DW)) u_pair (
    .clk(clk), .rst(rst), .sleep(sleep),
    .in_valid(in_valid), .in_ready(in_ready), .in_sel(in_sel), .in_data(in_data),
    .pair_take(take), .pair_vld(pair_vld), .pair_i(pair_i), .pair_q(pair_q),
    .pair_err(pair_err)
  );

  iqi_sched #(.PRIME(PRIME)) u_sched (
    .clk(clk), .rst(rst), .sleep(sleep), .pair_vld(pair_vld), .out_ready(out_ready),
    .take(take), .emit_a(emit_a), .emit_b(emit_b), .out_valid(out_valid)
  );

  assign ch_x[0] = pair_i;
  assign ch_x[1] = pair_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iqi_hb_chan #(.DW(DW), .K_IN(K_IN), .K_OUT(K_OUT), .SH(SH)) u_hb (
      .clk(clk), .clr(rst || sleep), .shift(take),
      .x_in(ch_x[c]), .y_a(ch_a[c]), .y_b(ch_b[c])
    );
  end

  // both DAC codes change on the same edge
  always_ff @(posedge clk) begin
    if (rst || sleep) begin
      out_i <= MID;
      out_q <= MID;
    end else if (emit_a) begin
      out_i <= ch_a[0];
      out_q <= ch_a[1];
    end else if (emit_b) begin
      out_i <= ch_b[0];
      out_q <= ch_b[1];
    end
  end

  // R7: a stalled beat stays put
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !sleep) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  // R9: sleep parks the outputs at mid-scale
  a_r9_sleep_mid: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!out_valid && out_i == MID && out_q == MID));

  // R10: reset clears the outputs and the error flag
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !pair_err && out_i == MID && out_q == MID));
endmodule

// File: tb/iq_interp2x_bench.sv
module iq_interp2x_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MIDC = 512;

  logic clk = 1'b0;
  logic rst = 1'b1, sleep = 1'b0, in_valid = 1'b0, in_sel = 1'b0, out_ready = 1'b0;
  logic [9:0] in_data = '0;
  logic in_ready, out_valid, pair_err;
  logic [9:0] out_i, out_q;

  iq_interp2x u_iq_interp2x (
    .clk(clk), .rst(rst), .sleep(sleep), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .pair_err(pair_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, beats = 0;
  bit done = 0;
  string req = "R5";

  // model state
  bit have_i = 0; int ival = 0; int npairs = 0;
  int hi [4]; int hq [4];
  int expi [$]; int expq [$];
  bit exp_err = 0, prev_hold = 0, prev_sleep = 0, last_acc = 0;
  int held_i = 0, held_q = 0;

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic int mix(int a, int b, int c, int d);
    int s;
    int r;
    s = -(a - MIDC) + 9 * (b - MIDC) + 9 * (c - MIDC) - (d - MIDC) + 8;
    r = s >>> 4;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return r + MIDC;
  endfunction

  task automatic model_clear();
    have_i = 0; npairs = 0; exp_err = 0;
    expi.delete(); expq.delete();
    for (int k = 0; k < 4; k++) begin hi[k] = MIDC; hq[k] = MIDC; end
  endtask

  task automatic commit(input int vi, input int vq);
    for (int k = 3; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
    hi[0] = vi; hq[0] = vq;
    npairs++;
    if (npairs >= 4) begin
      expi.push_back(mix(hi[0], hi[1], hi[2], hi[3]));
      expq.push_back(mix(hq[0], hq[1], hq[2], hq[3]));
      expi.push_back(hi[1]);
      expq.push_back(hq[1]);
    end
  endtask

  // evaluate ports after driving, well away from the edge
  task automatic step();
    int ei, eq;
    chk("R2", "pair_err", int'(pair_err), int'(exp_err));
    if (prev_hold) begin
      chk("R7", "held valid", int'(out_valid), 1);
      chk("R7", "held out_i", int'(out_i), held_i);
      chk("R7", "held out_q", int'(out_q), held_q);
    end
    if (prev_sleep) begin
      chk("R9", "sleep valid", int'(out_valid), 0);
      chk("R9", "sleep out_i", int'(out_i), MIDC);
      chk("R9", "sleep out_q", int'(out_q), MIDC);
    end
    if (out_valid && out_ready) begin
      beats++;
      if (expi.size() == 0) begin
        chk(req, "unexpected beat", 1, 0);
      end else begin
        ei = expi.pop_front(); eq = expq.pop_front();
        chk(req, "out_i", int'(out_i), ei);
        chk(req, "out_q", int'(out_q), eq);
      end
    end
    if (sleep) chk("R8", "in_ready in sleep", int'(in_ready), 0);
    last_acc = in_valid && in_ready;
    exp_err = 0;
    if (last_acc) begin
      if (in_sel) begin have_i = 1; ival = int'(in_data); end
      else if (have_i) begin have_i = 0; commit(ival, int'(in_data)); end
      else exp_err = 1;
    end
    if (sleep) model_clear();
    prev_hold = out_valid && !out_ready && !sleep;
    held_i = int'(out_i); held_q = int'(out_q);
    prev_sleep = sleep;
  endtask

  task automatic cyc(input bit v, input bit s, input int d, input bit rdy, input bit slp);
    @(negedge clk);
    in_valid = v; in_sel = s; in_data = 10'(d); out_ready = rdy; sleep = slp;
    #1;
    step();
  endtask

  task automatic send_word(input bit s, input int d);
    do cyc(1, s, d, 1, 0); while (!last_acc);
  endtask

  task automatic send_pair(input int vi, input int vq);
    send_word(1, vi);
    send_word(0, vq);
  endtask

  task automatic drain(input int n);
    repeat (n) cyc(0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R10: reset state
    chk("R10", "out_valid", int'(out_valid), 0);
    chk("R10", "out_i", int'(out_i), MIDC);
    chk("R10", "out_q", int'(out_q), MIDC);
    chk("R10", "pair_err", int'(pair_err), 0);
    chk("R10", "in_ready", int'(in_ready), 1);

    // R6: three pairs only prime the history
    req = "R6";
    beats = 0;
    send_pair(100, 900); send_pair(200, 800); send_pair(300, 700);
    drain(8);
    chk("R6", "beats after three pairs", beats, 0);
    send_pair(400, 600);
    drain(6);
    chk("R6", "beats after fourth pair", beats, 2);

    // R3 / R5: ordinary values
    req = "R3";
    send_pair(512, 512); send_pair(37, 1000); send_pair(777, 3);
    drain(8);
    chk("R5", "queue empty", expi.size(), 0);

    // R4: windows that clamp high on I and low on Q
    req = "R4";
    send_pair(0, 1023); send_pair(1023, 0); send_pair(1023, 0); send_pair(0, 1023);
    drain(8);
    chk("R4", "clamp high code", mix(0, 1023, 1023, 0), 1023);
    chk("R4", "clamp low code", mix(1023, 0, 0, 1023), 0);

    // R2: orphan Q words; R1: I override
    req = "R2";
    cyc(1, 0, 55, 1, 0); cyc(1, 0, 66, 1, 0); cyc(0, 0, 0, 1, 0);
    req = "R1";
    send_word(1, 11); send_word(1, 222); send_word(0, 333);
    send_pair(444, 555); send_pair(666, 10);
    drain(8);
    chk("R1", "queue empty", expi.size(), 0);

    // R11: full-rate alternation
    req = "R11";
    for (int k = 0; k < 40; k++) begin
      cyc(1, (k % 2) == 0, int'($urandom_range(0, 1023)), 1, 0);
      chk("R11", "in_ready at full rate", int'(in_ready), 1);
    end
    drain(6);

    // R9: sleep while a beat is stalled, then history restarts
    req = "R9";
    send_pair(10, 20); send_pair(30, 40); send_pair(50, 60); send_pair(70, 80);
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1); cyc(1, 1, 5, 0, 1); cyc(0, 0, 0, 1, 0);
    beats = 0;
    send_pair(1, 2); send_pair(3, 4); send_pair(5, 6);
    drain(6);
    chk("R9", "no beats while re-priming", beats, 0);

    // random phase: back-pressure, orphans, overrides, rare sleep
    req = "R7";
    void'($urandom(32'd4242));
    for (int k = 0; k < 30000; k++) begin
      bit v, s, r, z;
      v = ($urandom_range(0, 9) < 7);
      s = ($urandom_range(0, 9) < 5);
      r = ($urandom_range(0, 9) < 6);
      z = ($urandom_range(0, 999) < 4);
      cyc(v, s, int'($urandom_range(0, 1023)), r, z);
    end
    req = "R5";
    drain(10);
    chk("R5", "final queue empty", expi.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule